// File: doc/BRIEF.md
# High Bit-Error-Rate Monitor

This block watches the two-bit synchronization header that precedes each 66-bit block on a 10GBASE-R style receive path. While the upstream aligner reports block lock, every invalid header on a valid block is counted inside a fixed window equal to 125 µs of receive clock. When one window holds more than 16 such headers, a high-BER status flag is raised. The flag stays up until a whole window passes with 16 or fewer bad headers.

Two event counters run next to the window logic. One counts entries into the bad-header state, which happen once per counted invalid header. The other counts entries of the downstream receive decoder into its error state; these arrive as a one-cycle pulse on an input. Each counter is 16 bits, saturates, and has its own clear input. Link-status logic reads the flag to decide whether the link is usable. Management logic reads the two counters as error statistics.

Top module: `hber_monitor`

## Requirements
- R1: An invalid header is a sync header value of 2'b00 or 2'b11 seen in a cycle where both `blkValid` and `blkLock` are high. Headers 2'b01 and 2'b10 are never counted, and neither is any header while `blkValid` or `blkLock` is low.
- R2: The window is `WINDOW_CYCLES` consecutive locked cycles, starting with the first cycle of lock. The per-window count restarts at zero after the last cycle of each window, so invalid headers in different windows never add up.
- R3: `highBer` goes high on the clock edge at which the current window's count first exceeds `BER_LIMIT` (default 16). With exactly 16 invalid headers in a window it stays low.
- R4: Once high, `highBer` stays high through any window holding more than `BER_LIMIT` invalid headers. It falls at the edge that ends a window holding `BER_LIMIT` or fewer.
- R5: While `blkLock` is low, the window timer, the per-window count and `highBer` are cleared at the next edge. Both event counters keep their values.
- R6: `badHdrEntryCnt` increases by exactly one for each invalid header counted under R1.
- R7: `errBlkCnt` increases by one for each cycle in which `decErrEntry` is high, whether or not lock is held.
- R8: Both event counters stop at 65535 and do not wrap.
- R9: `badHdrCntClr` zeroes only `badHdrEntryCnt`, and `errBlkCntClr` zeroes only `errBlkCnt`. A clear wins over an event in the same cycle, so the counter reads zero after that edge.
- R10: While `rstN` is low, all outputs are held at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive parallel clock |
| rstN | input | 1 | Active-low synchronous reset |
| blkValid | input | 1 | A 66-bit block with its header is present this cycle |
| syncHdr | input | 2 | Synchronization header of the present block |
| blkLock | input | 1 | Block lock reported by the aligner |
| decErrEntry | input | 1 | One-cycle pulse: receive decoder entered its error state |
| badHdrCntClr | input | 1 | Clear the bad-header entry counter |
| errBlkCntClr | input | 1 | Clear the errored-block counter |
| highBer | output | 1 | High bit-error-rate status |
| badHdrEntryCnt | output | 16 | Saturating count of bad-header state entries |
| errBlkCnt | output | 16 | Saturating count of decoder error-state entries |

## Verification
The assertions check, on every cycle, the properties that hold edge by edge. The flag may only rise while lock is held, and loss of lock drops it. Each counter moves by at most one step, holds when no qualifying event occurred, keeps its value across loss of lock, and reads zero after its clear. Only the bench scenarios can show the window-level behaviour: 16 bad headers leave the flag low and 17 raise it, counts do not carry across a window boundary, the flag holds through a bad window and falls only when a clean window ends, and both counters stop at 65535. The bench shows these with a behavioural model compared every cycle and with directed checks at window edges.

// File: rtl/hber_pkg.sv
package hber_pkg;

  // Strobes passed from the control half to the datapath half each cycle
  typedef struct packed {
    logic badHdr;    // counted invalid header this cycle
    logic winEnd;    // last cycle of the current window
    logic unlocked;  // block lock is absent
    logic errEvt;    // decoder error-state entry
    logic clrBad;    // clear bad-header entry counter
    logic clrErr;    // clear errored-block counter
  } hberStrobes_t;

  function automatic logic hdrIsInvalid(input logic [1:0] hdr);
    return (hdr == 2'b00) || (hdr == 2'b11);
  endfunction

endpackage

// File: rtl/hber_satcnt.sv
module hber_satcnt #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  input  logic             clr,
  output logic [WIDTH-1:0] cnt
);
  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && (cnt != CNT_MAX)) begin
      cnt <= cnt + WIDTH'(1);
    end
  end
endmodule

// File: rtl/hber_ctrl.sv
module hber_ctrl
  import hber_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         blkValid,
  input  logic [1:0]   syncHdr,
  input  logic         blkLock,
  input  logic         decErrEntry,
  input  logic         badHdrCntClr,
  input  logic         errBlkCntClr,
  output hberStrobes_t strobes
);
  localparam int TW = (WINDOW_CYCLES > 2) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [TW-1:0] LAST_TICK = TW'(WINDOW_CYCLES - 1);

  logic [TW-1:0] winTimer;
  logic          atLast;

  assign atLast = (winTimer == LAST_TICK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      winTimer <= '0;
    end else if (!blkLock || atLast) begin
      winTimer <= '0;
    end else begin
      winTimer <= winTimer + TW'(1);
    end
  end

  always_comb begin
    strobes.badHdr   = blkLock && blkValid && hdrIsInvalid(syncHdr);
    strobes.winEnd   = blkLock && atLast;
    strobes.unlocked = !blkLock;
    strobes.errEvt   = decErrEntry;
    strobes.clrBad   = badHdrCntClr;
    strobes.clrErr   = errBlkCntClr;
  end
endmodule

// File: rtl/hber_datapath.sv
module hber_datapath
  import hber_pkg::*;
#(
  parameter int BER_LIMIT = 16,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  hberStrobes_t     strobes,
  output logic             highBer,
  output logic [CNT_W-1:0] badHdrEntryCnt,
  output logic [CNT_W-1:0] errBlkCnt
);
  localparam int WC_W = $clog2(BER_LIMIT + 2);
  localparam logic [WC_W-1:0] WC_SAT   = WC_W'(BER_LIMIT + 1);
  localparam logic [WC_W-1:0] WC_LIMIT = WC_W'(BER_LIMIT);

  logic [WC_W-1:0] winCnt;
  logic [WC_W-1:0] winCntNext;
  logic            overLimit;

  // window count saturates just above the limit; nothing beyond is needed
  assign winCntNext = (winCnt == WC_SAT) ? WC_SAT : winCnt + WC_W'(strobes.badHdr);
  assign overLimit  = (winCntNext > WC_LIMIT);

  always_ff @(posedge clk) begin
    if (!rstN || strobes.unlocked) begin
      winCnt  <= '0;
      highBer <= 1'b0;
    end else if (strobes.winEnd) begin
      winCnt  <= '0;
      highBer <= overLimit;
    end else begin
      winCnt <= winCntNext;
      if (overLimit) highBer <= 1'b1;
    end
  end

  logic [1:0]             evtInc;
  logic [1:0]             evtClr;
  logic [1:0][CNT_W-1:0]  evtCnt;

  assign evtInc = {strobes.errEvt, strobes.badHdr};
  assign evtClr = {strobes.clrErr, strobes.clrBad};

  for (genvar g = 0; g < 2; g++) begin : gEvtCnt
    hber_satcnt #(.WIDTH(CNT_W)) u_cnt (
      .clk  (clk),
      .rstN (rstN),
      .inc  (evtInc[g]),
      .clr  (evtClr[g]),
      .cnt  (evtCnt[g])
    );
  end

  assign badHdrEntryCnt = evtCnt[0];
  assign errBlkCnt      = evtCnt[1];
endmodule

// File: rtl/hber_monitor.sv
module hber_monitor
  import hber_pkg::*;
#(
  parameter int WINDOW_CYCLES = 64,
  parameter int BER_LIMIT     = 16,
  parameter int CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             blkValid,
  input  logic [1:0]       syncHdr,
  input  logic             blkLock,
  input  logic             decErrEntry,
  input  logic             badHdrCntClr,
  input  logic             errBlkCntClr,
  output logic             highBer,
  output logic [CNT_W-1:0] badHdrEntryCnt,
  output logic [CNT_W-1:0] errBlkCnt
);
  hberStrobes_t strobes;

  hber_ctrl #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .blkValid     (blkValid),
    .syncHdr      (syncHdr),
    .blkLock      (blkLock),
    .decErrEntry  (decErrEntry),
    .badHdrCntClr (badHdrCntClr),
    .errBlkCntClr (errBlkCntClr),
    .strobes      (strobes)
  );

  hber_datapath #(.BER_LIMIT(BER_LIMIT), .CNT_W(CNT_W)) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .highBer        (highBer),
    .badHdrEntryCnt (badHdrEntryCnt),
    .errBlkCnt      (errBlkCnt)
  );
endmodule

// File: rtl/hber_monitor_checker.sv
module hber_monitor_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             blkValid,
  input logic [1:0]       syncHdr,
  input logic             blkLock,
  input logic             decErrEntry,
  input logic             badHdrCntClr,
  input logic             errBlkCntClr,
  input logic             highBer,
  input logic [CNT_W-1:0] badHdrEntryCnt,
  input logic [CNT_W-1:0] errBlkCnt
);
  logic hdrCounted;
  assign hdrCounted = blkLock && blkValid && (syncHdr == 2'b00 || syncHdr == 2'b11);

  assert_rise_needs_lock_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(highBer) |-> $past(blkLock));

  assert_unlock_drops_flag_R5: assert property (@(posedge clk) disable iff (!rstN)
    !blkLock |=> !highBer);

  assert_unlock_keeps_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!blkLock && !badHdrCntClr) |=> $stable(badHdrEntryCnt));

  assert_only_invalid_counted_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!hdrCounted && !badHdrCntClr) |=> $stable(badHdrEntryCnt));

  assert_bad_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    !badHdrCntClr |=> (badHdrEntryCnt == $past(badHdrEntryCnt)) ||
                      (badHdrEntryCnt == $past(badHdrEntryCnt) + CNT_W'(1)));

  assert_err_step_R7: assert property (@(posedge clk) disable iff (!rstN)
    !errBlkCntClr |=> (errBlkCnt == $past(errBlkCnt)) ||
                      (errBlkCnt == $past(errBlkCnt) + CNT_W'(1)));

  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!decErrEntry && !errBlkCntClr) |=> $stable(errBlkCnt));

  assert_bad_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    badHdrCntClr |=> badHdrEntryCnt == '0);

  assert_err_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    errBlkCntClr |=> errBlkCnt == '0);
endmodule

bind hber_monitor hber_monitor_checker #(.CNT_W(CNT_W)) u_chk (.*);

// File: tb/hber_monitor_bench.sv
`timescale 1ns/1ps
module hber_monitor_bench;
  localparam int W     = 64;
  localparam int LIMIT = 16;
  localparam int CMAX  = 65535;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic blkValid = 1'b0, blkLock = 1'b0, decErrEntry = 1'b0;
  logic badHdrCntClr = 1'b0, errBlkCntClr = 1'b0;
  logic [1:0] syncHdr = 2'b01;
  logic highBer;
  logic [15:0] badHdrEntryCnt, errBlkCnt;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hber_monitor #(.WINDOW_CYCLES(W), .BER_LIMIT(LIMIT), .CNT_W(16)) u_hber_monitor (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .syncHdr(syncHdr),
    .blkLock(blkLock), .decErrEntry(decErrEntry), .badHdrCntClr(badHdrCntClr),
    .errBlkCntClr(errBlkCntClr), .highBer(highBer),
    .badHdrEntryCnt(badHdrEntryCnt), .errBlkCnt(errBlkCnt)
  );

  // behavioural reference
  int mTimer = 0, mWin = 0, mBad = 0, mErr = 0;
  bit mHigh = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mTimer = 0; mWin = 0; mHigh = 0; mBad = 0; mErr = 0;
    end else begin
      automatic bit bad = blkLock && blkValid && (syncHdr == 2'b00 || syncHdr == 2'b11);
      automatic int tot;
      if (!blkLock) begin
        mTimer = 0; mWin = 0; mHigh = 0;
      end else begin
        tot = mWin + (bad ? 1 : 0);
        if (tot > LIMIT) mHigh = 1;
        if (mTimer == W - 1) begin
          if (tot <= LIMIT) mHigh = 0;
          mWin = 0; mTimer = 0;
        end else begin
          mWin = tot; mTimer = mTimer + 1;
        end
      end
      if (badHdrCntClr) mBad = 0; else if (bad && mBad < CMAX) mBad = mBad + 1;
      if (errBlkCntClr) mErr = 0; else if (decErrEntry && mErr < CMAX) mErr = mErr + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      check("R3/R4 highBer vs model", int'(highBer), int'(mHigh));
      check("R6 badHdrEntryCnt vs model", int'(badHdrEntryCnt), mBad);
      check("R7 errBlkCnt vs model", int'(errBlkCnt), mErr);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic runWindow(input int nBad, input int len);
    for (int i = 0; i < len; i++) begin
      blkValid = 1'b1;
      if (i < nBad) syncHdr = (i % 2 != 0) ? 2'b00 : 2'b11;
      else          syncHdr = (i % 2 != 0) ? 2'b01 : 2'b10;
      step();
    end
  endtask

  task automatic relock();
    blkLock = 1'b0; blkValid = 1'b0; step();
    blkLock = 1'b1;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    int saved;
    repeat (3) step();
    // R10: outputs held at zero in reset
    check("R10 highBer in reset", int'(highBer), 0);
    check("R10 badHdrEntryCnt in reset", int'(badHdrEntryCnt), 0);
    check("R10 errBlkCnt in reset", int'(errBlkCnt), 0);
    rstN = 1'b1;

    // R1: valid headers, and invalid headers without blkValid, are ignored
    blkLock = 1'b1;
    runWindow(0, W);
    for (int i = 0; i < 8; i++) begin
      blkValid = 1'b0; syncHdr = (i % 2 != 0) ? 2'b00 : 2'b11; step();
    end
    check("R1 nothing counted", int'(badHdrEntryCnt), 0);

    // R3: exactly the limit leaves the flag low
    relock();
    runWindow(LIMIT, W);
    check("R3 limit not exceeded", int'(highBer), 0);
    check("R6 sixteen counted", int'(badHdrEntryCnt), 16);

    // R3: one more raises it within the window
    relock();
    runWindow(LIMIT + 1, LIMIT + 1);
    check("R3 rise on 17th", int'(highBer), 1);
    runWindow(0, W - LIMIT - 1);
    check("R4 held at window end", int'(highBer), 1);

    // R4: a bad window keeps it, a clean window clears it at its end
    runWindow(LIMIT + 1, W);
    check("R4 held through bad window", int'(highBer), 1);
    runWindow(0, W - 1);
    check("R4 still high before clean window ends", int'(highBer), 1);
    runWindow(0, 1);
    check("R4 falls after clean window", int'(highBer), 0);

    // R2: counts do not carry across windows
    relock();
    runWindow(10, W);
    runWindow(10, W);
    check("R2 split counts", int'(highBer), 0);

    // R5: loss of lock clears the flag, counters kept
    relock();
    runWindow(LIMIT + 1, W);
    check("R5 flag set before unlock", int'(highBer), 1);
    saved = int'(badHdrEntryCnt);
    blkLock = 1'b0; blkValid = 1'b1; syncHdr = 2'b11; step();
    check("R5 flag cleared on unlock", int'(highBer), 0);
    check("R5 count kept on unlock", int'(badHdrEntryCnt), saved);
    check("R1 no count without lock", int'(badHdrEntryCnt), saved);

    // R7: decoder error entries counted without lock
    blkValid = 1'b0;
    decErrEntry = 1'b1; repeat (3) step();
    decErrEntry = 1'b0; step();
    check("R7 three entries", int'(errBlkCnt), 3);

    // R9: clear beats event and leaves the other counter
    decErrEntry = 1'b1; errBlkCntClr = 1'b1; step();
    decErrEntry = 1'b0; errBlkCntClr = 1'b0;
    check("R9 err clear wins", int'(errBlkCnt), 0);
    check("R9 bad count untouched", int'(badHdrEntryCnt), saved);
    blkLock = 1'b1; blkValid = 1'b1; syncHdr = 2'b00; badHdrCntClr = 1'b1;
    decErrEntry = 1'b1; step();
    badHdrCntClr = 1'b0; decErrEntry = 1'b0; syncHdr = 2'b01;
    check("R9 bad clear wins", int'(badHdrEntryCnt), 0);
    check("R9 err untouched by bad clear", int'(errBlkCnt), 1);

    // R8: saturation of both counters
    syncHdr = 2'b11; decErrEntry = 1'b1;
    repeat (CMAX + 5) step();
    check("R8 bad saturates", int'(badHdrEntryCnt), CMAX);
    check("R8 err saturates", int'(errBlkCnt), CMAX);
    step();
    check("R8 bad stays at max", int'(badHdrEntryCnt), CMAX);
    check("R8 err stays at max", int'(errBlkCnt), CMAX);
    decErrEntry = 1'b0; blkValid = 1'b0;
    step();
    finishRun();
  end
endmodule